// File: doc/BRIEF.md
# Binary-Tree Identifier Lookup Engine

This block turns a peripheral identifier into a channel number. The identifier is built from a 4-bit slave number and an 8-bit peripheral number. The block finds the channel by walking a decision tree stored as node words in an internal table. Each node tests one bit of the identifier. The chosen branch then either names the next node to visit or gives the final channel number. One node is visited per clock cycle, and the walk stops after a fixed number of visits.

Software loads the tree through a one-word write port, one node per write. A lookup begins with a single-cycle start pulse that carries the identifier. When the walk ends, the block pulses a done strobe for one cycle. In that same cycle it shows whether a channel was found and, if so, which one.

Top module: `bt_id_lookup`

## Requirements
- R1: The identifier is `{sid_i, periph_i}`. The slave number occupies identifier bits 11:8 and the peripheral number occupies bits 7:0.
- R2: A start pulse accepted while idle always begins the walk at table entry 0.
- R3: Node bits 3:0 give the identifier bit to test. A value of 1 selects the one-branch pair and a value of 0 selects the zero-branch pair. A bit index of 12 or more reads as 0.
- R4: Each branch has a link flag and an 8-bit result. The zero branch uses bit 4 as its flag and bits 12:5 as its result. The one branch uses bit 13 as its flag and bits 21:14 as its result. When the flag is set, the result is the index of the next node. When the flag is clear, the walk ends with found=1 and the channel equal to the result.
- R5: At most MAX_VISITS nodes (8) are visited. If the last permitted node also chooses a link, the walk ends with found=0.
- R6: A link whose target is not below ENTRIES (128) ends the walk at once with found=0.
- R7: One node is visited per cycle. If the walk visits v nodes, done is seen in the cycle that follows v+1 rising edges, counting the edge that accepted the start.
- R8: A start pulse that arrives while a walk is running is ignored. It neither changes the result nor produces an extra done.
- R9: done is high for exactly one cycle. found and channel read 0 whenever done is low.
- R10: Reset clears every table word to 0 and leaves the engine idle with done, found and channel low. A word written through the write port is used by later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle lookup request |
| sid_i | input | 4 | Slave number, upper identifier bits |
| periph_i | input | 8 | Peripheral number, lower identifier bits |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 7 | Table entry to write |
| wr_data_i | input | 32 | Node word to store |
| done_o | output | 1 | Lookup finished, one-cycle pulse |
| found_o | output | 1 | A terminal result was reached |
| chan_o | output | 8 | Channel number when found |

## Verification
The bench builds the block with its default parameters, ENTRIES=128 and MAX_VISITS=8. With 8 visits allowed, a chain of eight nodes can be built in a small table. That lets the bench test both sides of the depth limit: one identifier ends at a terminal on the eighth visit, and another follows a link there and is reported as not found. With 128 entries, an 8-bit link result of 200 points outside the table, so the out-of-range case can be reached with an ordinary node word. A bit index of 13 exercises the read-as-zero rule.

// File: rtl/bt_lookup_pkg.sv
package bt_lookup_pkg;

    // Node word field positions; the walker decodes these.
    localparam int NODE_W      = 32;
    localparam int RES_W       = 8;
    localparam int BIDX_W      = 4;
    localparam int BIDX_LSB    = 0;
    localparam int ZLINK_BIT   = 4;
    localparam int ZRES_LSB    = 5;
    localparam int OLINK_BIT   = 13;
    localparam int ORES_LSB    = 14;
    localparam int BIT_SPACE   = 1 << BIDX_W;

    typedef struct packed {
        logic [BIDX_W-1:0] bit_idx;
        logic              zero_link;
        logic [RES_W-1:0]  zero_res;
        logic              one_link;
        logic [RES_W-1:0]  one_res;
    } node_t;

    function automatic node_t unpack_node(input logic [NODE_W-1:0] w);
        node_t n;
        n.bit_idx   = w[BIDX_LSB +: BIDX_W];
        n.zero_link = w[ZLINK_BIT];
        n.zero_res  = w[ZRES_LSB +: RES_W];
        n.one_link  = w[OLINK_BIT];
        n.one_res   = w[ORES_LSB +: RES_W];
        return n;
    endfunction

endpackage

// File: rtl/bt_node_table.sv
module bt_node_table #(
    parameter int ENTRIES = 128,
    parameter int WORD_W  = 32,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem_d [ENTRIES];
    logic [WORD_W-1:0] mem_q [ENTRIES];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R10: a written word is visible at its entry after the edge
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/bt_node_decode.sv
module bt_node_decode
    import bt_lookup_pkg::*;
#(
    parameter int ID_W    = 12,
    parameter int ENTRIES = 128
) (
    input  logic [NODE_W-1:0] node_word,
    input  logic [ID_W-1:0]   id,
    output logic              take_link,
    output logic              link_in_range,
    output logic [RES_W-1:0]  result
);

    node_t                node;
    logic [BIT_SPACE-1:0] id_ext;
    logic                 tested;

    always_comb begin
        node   = unpack_node(node_word);
        id_ext = BIT_SPACE'(id);
        // indices past the identifier width land on zero-extended bits
        tested = id_ext[node.bit_idx];
        if (tested) begin
            take_link = node.one_link;
            result    = node.one_res;
        end else begin
            take_link = node.zero_link;
            result    = node.zero_res;
        end
        link_in_range = (32'(result) < ENTRIES);
    end

endmodule

// File: rtl/bt_walk_ctrl.sv
module bt_walk_ctrl
    import bt_lookup_pkg::*;
#(
    parameter int ID_W       = 12,
    parameter int ENTRIES    = 128,
    parameter int MAX_VISITS = 8,
    localparam int AW        = $clog2(ENTRIES),
    localparam int SW        = (MAX_VISITS > 1) ? $clog2(MAX_VISITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ID_W-1:0]  id_i,
    input  logic             take_link,
    input  logic             link_in_range,
    input  logic [RES_W-1:0] result,
    output logic [AW-1:0]    node_idx,
    output logic [ID_W-1:0]  walk_id,
    output logic             done_o,
    output logic             found_o,
    output logic [RES_W-1:0] chan_o
);

    typedef struct packed {
        logic             busy;
        logic [ID_W-1:0]  id;
        logic [AW-1:0]    node;
        logic [SW-1:0]    step;
        logic             done;
        logic             found;
        logic [RES_W-1:0] chan;
    } walk_t;

    walk_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.found = 1'b0;
        s_d.chan  = '0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy = 1'b1;
                s_d.id   = id_i;
                s_d.node = '0;
                s_d.step = '0;
            end
        end else if (!take_link) begin
            s_d.busy  = 1'b0;
            s_d.done  = 1'b1;
            s_d.found = 1'b1;
            s_d.chan  = result;
        end else if (!link_in_range || s_q.step == SW'(MAX_VISITS - 1)) begin
            s_d.busy  = 1'b0;
            s_d.done  = 1'b1;
        end else begin
            s_d.node = AW'(result);
            s_d.step = s_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign node_idx = s_q.node;
    assign walk_id  = s_q.id;
    assign done_o   = s_q.done;
    assign found_o  = s_q.found;
    assign chan_o   = s_q.chan;

    p_root_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && start_i) |=> (s_q.busy && s_q.node == '0 && s_q.step == '0));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && start_i) |=> $stable(s_q.id));

    p_visit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (32'(s_q.step) < MAX_VISITS));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    p_quiet_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.done |-> (!s_q.found && s_q.chan == '0));

    p_found_terminal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && s_q.found) |-> $past(!take_link));

endmodule

// File: rtl/bt_id_lookup.sv
module bt_id_lookup
    import bt_lookup_pkg::*;
#(
    parameter int SID_W      = 4,
    parameter int PER_W      = 8,
    parameter int ENTRIES    = 128,
    parameter int MAX_VISITS = 8,
    localparam int ID_W      = SID_W + PER_W,
    localparam int AW        = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SID_W-1:0]  sid_i,
    input  logic [PER_W-1:0]  periph_i,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [NODE_W-1:0] wr_data_i,
    output logic              done_o,
    output logic              found_o,
    output logic [RES_W-1:0]  chan_o
);

    logic [ID_W-1:0]   req_id;
    logic [ID_W-1:0]   walk_id;
    logic [AW-1:0]     node_idx;
    logic [NODE_W-1:0] node_word;
    logic              take_link;
    logic              link_in_range;
    logic [RES_W-1:0]  result;

    // R1: slave number above peripheral number
    assign req_id = {sid_i, periph_i};

    bt_node_table #(.ENTRIES(ENTRIES), .WORD_W(NODE_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .rd_addr (node_idx),
        .rd_data (node_word)
    );

    bt_node_decode #(.ID_W(ID_W), .ENTRIES(ENTRIES)) u_decode (
        .node_word     (node_word),
        .id            (walk_id),
        .take_link     (take_link),
        .link_in_range (link_in_range),
        .result        (result)
    );

    bt_walk_ctrl #(.ID_W(ID_W), .ENTRIES(ENTRIES), .MAX_VISITS(MAX_VISITS)) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .id_i          (req_id),
        .take_link     (take_link),
        .link_in_range (link_in_range),
        .result        (result),
        .node_idx      (node_idx),
        .walk_id       (walk_id),
        .done_o        (done_o),
        .found_o       (found_o),
        .chan_o        (chan_o)
    );

endmodule

// File: tb/bt_id_lookup_test.sv
`timescale 1ns/1ps
module bt_id_lookup_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  sid_i = '0;
    logic [7:0]  periph_i = '0;
    logic        wr_en_i = 1'b0;
    logic [6:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        done_o;
    logic        found_o;
    logic [7:0]  chan_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    bt_id_lookup uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sid_i(sid_i),
        .periph_i(periph_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .done_o(done_o), .found_o(found_o), .chan_o(chan_o)
    );

    // vector: {sid, periph, found, chan, cycles-to-done}
    localparam int NV = 8;
    localparam logic [24:0] VECS [NV] = '{
        {4'h0, 8'h00, 1'b1, 8'h10, 4'd3},  // R4 short terminal
        {4'h0, 8'h01, 1'b0, 8'h00, 4'd9},  // R5 link on 8th visit
        {4'h0, 8'h05, 1'b1, 8'h5F, 4'd9},  // R5 terminal on 8th visit
        {4'h0, 8'h03, 1'b1, 8'h4A, 4'd4},  // R3 one-branch taken
        {4'h8, 8'h00, 1'b1, 8'h30, 4'd4},  // R1 R3 slave bit 11, index 13 reads 0
        {4'h8, 8'h10, 1'b0, 8'h00, 4'd4},  // R6 link to 200
        {4'h9, 8'h00, 1'b1, 8'h30, 4'd4},  // R1 bit 8 untested
        {4'h7, 8'hFF, 1'b1, 8'h4A, 4'd4}   // R1 slave 7 has bit 11 clear
    };

    function automatic logic [31:0] mk(input logic [3:0] bi, input logic zl,
                                       input logic [7:0] zr, input logic ol,
                                       input logic [7:0] orr);
        return {10'b0, orr, ol, zr, zl, bi};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_node(input int addr, input logic [31:0] w);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 7'(addr); wr_data_i = w;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic run(input logic [3:0] s, input logic [7:0] p,
                       output logic f, output logic [7:0] c, output int lat,
                       output int noisy);
        @(negedge clk);
        sid_i = s; periph_i = p; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1; noisy = 0;
        while (!done_o && lat < 40) begin
            if (found_o || chan_o != 8'h00) noisy = 1;
            @(negedge clk);
            lat++;
        end
        f = found_o; c = chan_o;
        @(negedge clk);
        chk("R9 done width", int'(done_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic f;
        logic [7:0] c;
        int lat, noisy, extra;

        repeat (3) @(negedge clk);
        chk("R10 reset done", int'(done_o), 0);
        chk("R10 reset found", int'(found_o), 0);
        chk("R10 reset chan", int'(chan_o), 0);
        rst_n = 1'b1;

        // R10: cleared table, node 0 is a terminal with channel 0
        run(4'h5, 8'h3C, f, c, lat, noisy);
        chk("R10 cleared found", int'(f), 1);
        chk("R10 cleared chan", int'(c), 0);
        chk("R7 single visit latency", lat, 2);

        // load tree
        wr_node(0,  mk(4'd11, 1'b1, 8'd1,  1'b1, 8'd2));
        wr_node(1,  mk(4'd0,  1'b0, 8'h10, 1'b1, 8'd10));
        wr_node(2,  mk(4'd13, 1'b1, 8'd3,  1'b0, 8'hEE));
        wr_node(3,  mk(4'd4,  1'b0, 8'h30, 1'b1, 8'd200));
        for (int k = 10; k < 15; k++) begin
            wr_node(k, mk(4'd1, 1'b1, 8'(k + 1), 1'b0, 8'h4A));
        end
        wr_node(15, mk(4'd2, 1'b1, 8'd16, 1'b0, 8'h5F));
        wr_node(16, mk(4'd0, 1'b0, 8'h66, 1'b0, 8'h66));

        for (int v = 0; v < NV; v++) begin
            run(VECS[v][24:21], VECS[v][20:13], f, c, lat, noisy);
            chk($sformatf("R4 R5 R6 vec%0d found", v), int'(f), int'(VECS[v][12]));
            chk($sformatf("R4 vec%0d chan", v), int'(c), int'(VECS[v][11:4]));
            chk($sformatf("R7 vec%0d latency", v), lat, int'(VECS[v][3:0]));
            chk($sformatf("R9 vec%0d quiet before done", v), noisy, 0);
        end

        // R8: second start during a long walk is ignored
        @(negedge clk);
        sid_i = 4'h0; periph_i = 8'h01; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        repeat (2) begin @(negedge clk); lat++; end
        sid_i = 4'h0; periph_i = 8'h00; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; lat++;
        while (!done_o && lat < 40) begin @(negedge clk); lat++; end
        chk("R8 latency unchanged", lat, 9);
        chk("R8 result of first id", int'(found_o), 0);
        extra = 0;
        repeat (5) begin @(negedge clk); if (done_o) extra++; end
        chk("R8 no extra done", extra, 0);

        // R10: overwrite root to a direct terminal
        wr_node(0, mk(4'd0, 1'b0, 8'h77, 1'b0, 8'h78));
        run(4'h0, 8'h01, f, c, lat, noisy);
        chk("R10 rewritten root chan", int'(c), 8'h78);
        chk("R2 walk starts at root", lat, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule